// File: doc/BRIEF.md
# Double-Word Load Execution Unit

This unit carries out one double-word load on a 16-bit, word-addressed machine. A start pulse comes with the instruction word, an optional second address word, the instruction-address value and the three index registers. The unit then forms an effective address in one of several ways. A short form adds a signed 8-bit displacement to the instruction address or to an index register. A long form uses a full 16-bit address, either alone or added to an index register. It can also go through one level of indirection.

After the address is formed, the unit reads two storage words through a synchronous, read-only memory port. The first word goes to the accumulator and the second to the accumulator extension. The second address is always the effective address with bit 0 set. An odd effective address therefore loads the same word into both registers. Every address form is legal. The unit raises no exception and writes no memory. It has no carry or overflow indicators and so cannot disturb them. A one-cycle done pulse marks the moment both registers hold the new values.

Top module: `ldd_exec`

## Requirements
- R1: While rst_n is low at a clock edge, and after it, done, acc and ext are 0 and mem_re is low until a start is accepted.
- R2: Instruction fields are bits [15:11] opcode (the unit assumes 11001b), bit 10 long format, bits [9:8] tag, bit 7 indirect (long format only) and bits [7:0] displacement (short format). Short format with tag 00 gives EA = iar + sign-extended displacement, modulo 2^16.
- R3: Short format with tag 1, 2 or 3 gives EA = xr1, xr2 or xr3 + sign-extended displacement, modulo 2^16. Bit 7 is only the displacement sign here and never causes indirection.
- R4: Long format without indirection gives EA = addr_word when the tag is 00, and addr_word + the selected index register modulo 2^16 otherwise.
- R5: Long format with bit 7 set reads the word at the R4 address and uses that word as EA.
- R6: After a load, acc holds mem[EA] and ext holds mem[EA | 1]. For an odd EA both registers hold mem[EA].
- R7: Counting the accepting edge, done is high for exactly one cycle after the 4th clock edge for a direct load and after the 6th edge for an indirect load. acc and ext change only at the edge that raises done and hold their values otherwise.
- R8: A start pulse that arrives while a load is in progress is ignored. That load completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load; the operands below are sampled at the same edge |
| instr_word | input | 16 | First instruction word |
| addr_word | input | 16 | Second instruction word (long format address) |
| iar | input | 16 | Address of the word following the instruction |
| xr1 | input | 16 | Index register 1 |
| xr2 | input | 16 | Index register 2 |
| xr3 | input | 16 | Index register 3 |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_re |
| acc | output | 16 | Accumulator |
| ext | output | 16 | Accumulator extension |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory returns data exactly one cycle after a strobe. They also assume that the operands are valid in the cycle start is high. The bench memory is a registered model of a fixed address hash, so it keeps to that latency by construction. The bench holds every operand steady through the start cycle. Random instruction words are built from the five-bit opcode field, with every format, tag and indirect bit allowed. Extra start pulses are sent deliberately while a load is in progress.

// File: rtl/ldd_pkg.sv
// Package: shared types for the double-word load unit.
// Assumes a 16-bit instruction word with an 8-bit short displacement.
package ldd_pkg;
    localparam int DISP_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR,
        S_PTRW,
        S_RD1,
        S_RD2,
        S_CAP
    } seq_state_t;

    typedef struct packed {
        logic              long_fmt;
        logic              indirect;
        logic [1:0]        tag;
        logic [DISP_W-1:0] disp;
    } ldd_fields_t;
endpackage

// File: rtl/ldd_decode.sv
// Module: field extraction from the first instruction word.
// Assumes the opcode was already matched by the issuing logic; the
// indirect flag is only honoured in long format.
module ldd_decode
    import ldd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] instr_word,
    output ldd_fields_t       fields
);
    localparam int LONG_BIT = WORD_W - 6;
    localparam int TAG_LO   = WORD_W - 8;
    localparam int IND_BIT  = DISP_W - 1;

    // Purpose: slice the format, tag, indirect and displacement fields.
    always_comb begin
        fields.long_fmt = instr_word[LONG_BIT];
        fields.tag      = instr_word[TAG_LO+1:TAG_LO];
        fields.disp     = instr_word[DISP_W-1:0];
        fields.indirect = instr_word[LONG_BIT] & instr_word[IND_BIT];
    end
endmodule

// File: rtl/ldd_addr_gen.sv
// Module: base address former (before any indirection).
// Short format: base register (iar or index) plus sign-extended
// displacement. Long format: address word plus optional index.
// All sums wrap modulo 2^WORD_W.
module ldd_addr_gen
    import ldd_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NUM_XR = 3
) (
    input  ldd_fields_t                  fields,
    input  logic [WORD_W-1:0]            addr_word,
    input  logic [WORD_W-1:0]            iar,
    input  logic [NUM_XR:1][WORD_W-1:0]  xr,
    output logic [WORD_W-1:0]            base_addr
);
    localparam int EXT_W = WORD_W - DISP_W;

    logic [NUM_XR:0][WORD_W-1:0] idx_tbl;
    logic [WORD_W-1:0]           idx_val;
    logic [WORD_W-1:0]           offset;

    // Purpose: entry 0 is the no-index base, entries 1..N the index registers.
    assign idx_tbl[0] = fields.long_fmt ? '0 : iar;
    for (genvar g = 1; g <= NUM_XR; g++) begin : g_idx
        assign idx_tbl[g] = xr[g];
    end

    // Purpose: pick the base register and offset, then add.
    always_comb begin
        idx_val = idx_tbl[fields.tag];
        if (fields.long_fmt)
            offset = addr_word;
        else
            offset = {{EXT_W{fields.disp[DISP_W-1]}}, fields.disp};
        base_addr = idx_val + offset;
    end
endmodule

// File: rtl/ldd_seq.sv
// Module: load sequencer. Steps through an optional pointer read, two
// data reads and a capture state, then pulses done for one cycle.
// Assumes one cycle of memory read latency. Start is ignored unless idle.
module ldd_seq
    import ldd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       indirect,
    output seq_state_t state,
    output logic       accept,
    output logic       done
);
    seq_state_t nxt;

    assign accept = start && (state == S_IDLE);

    // Purpose: next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (accept) nxt = indirect ? S_PTR : S_RD1;
            S_PTR:   nxt = S_PTRW;
            S_PTRW:  nxt = S_RD1;
            S_RD1:   nxt = S_RD2;
            S_RD2:   nxt = S_CAP;
            S_CAP:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Purpose: state register and registered done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == S_CAP);
        end
    end

    // R7: done never lasts more than one cycle
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done follows the capture state
    a_r7_done_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == S_CAP));

    // R8: a start during a load does not return the sequencer to idle early
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == S_RD1) |=> (state == S_RD2));
endmodule

// File: rtl/ldd_exec.sv
// Module: top of the double-word load unit. Samples the operands on an
// accepted start, forms the effective address, performs the reads and
// updates the accumulator and extension together.
// Assumes operands are valid while start is high and memory data
// arrives one cycle after mem_re. Never writes memory.
module ldd_exec
    import ldd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [WORD_W-1:0] addr_word,
    input  logic [WORD_W-1:0] iar,
    input  logic [WORD_W-1:0] xr1,
    input  logic [WORD_W-1:0] xr2,
    input  logic [WORD_W-1:0] xr3,
    output logic              mem_re,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] acc,
    output logic [WORD_W-1:0] ext,
    output logic              done
);
    localparam int NUM_XR = 3;

    ldd_fields_t                 fields;
    logic [NUM_XR:1][WORD_W-1:0] xr_vec;
    logic [WORD_W-1:0]           base_addr;
    logic [WORD_W-1:0]           ea_q;
    logic [WORD_W-1:0]           word1_q;
    seq_state_t                  state;
    logic                        accept;

    assign xr_vec = {xr3, xr2, xr1};

    ldd_decode #(.WORD_W(WORD_W)) u_decode (
        .instr_word (instr_word),
        .fields     (fields)
    );

    ldd_addr_gen #(.WORD_W(WORD_W), .NUM_XR(NUM_XR)) u_addr (
        .fields    (fields),
        .addr_word (addr_word),
        .iar       (iar),
        .xr        (xr_vec),
        .base_addr (base_addr)
    );

    ldd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .indirect (fields.indirect),
        .state    (state),
        .accept   (accept),
        .done     (done)
    );

    // Purpose: drive the read port from the sequencer state.
    always_comb begin
        mem_re   = (state == S_PTR) || (state == S_RD1) || (state == S_RD2);
        mem_addr = (state == S_RD2) ? (ea_q | WORD_W'(1)) : ea_q;
    end

    // Purpose: hold the pointer / effective address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ea_q <= '0;
        else if (accept)
            ea_q <= base_addr;
        else if (state == S_PTRW)
            ea_q <= mem_rdata;
    end

    // Purpose: stage the first word, then update both registers at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word1_q <= '0;
            acc     <= '0;
            ext     <= '0;
        end else begin
            if (state == S_RD2)
                word1_q <= mem_rdata;
            if (state == S_CAP) begin
                acc <= word1_q;
                ext <= mem_rdata;
            end
        end
    end

    // R6: the second data read targets the first with bit 0 set
    a_r6_pair_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD2) |-> (mem_re && mem_addr == ($past(mem_addr) | WORD_W'(1))));

    // R8: the effective address is frozen once data reads start
    a_r8_ea_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD2 || state == S_CAP) |-> $stable(ea_q));

    // R7: outputs change only at the completing edge
    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(acc) && $stable(ext)));

    // R7: no read is issued while done is shown
    a_r7_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_re);
endmodule

// File: tb/ldd_exec_tb.sv
module ldd_exec_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr_word = '0, addr_word = '0, iar = '0;
    logic [15:0] xr1 = '0, xr2 = '0, xr3 = '0;
    logic        mem_re;
    logic [15:0] mem_addr, mem_rdata, acc, ext;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldd_exec u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_word(instr_word),
        .addr_word(addr_word), .iar(iar), .xr1(xr1), .xr2(xr2), .xr3(xr3),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .acc(acc), .ext(ext), .done(done)
    );

    function automatic logic [15:0] mem_f(input logic [15:0] a);
        logic [31:0] p;
        p = a * 32'h9E37;
        return p[15:0] ^ 16'h5A5A ^ {a[2:0], a[15:3]};
    endfunction

    always_ff @(posedge clk) if (mem_re) mem_rdata <= mem_f(mem_addr);

    function automatic logic [15:0] exp_ea(input logic [15:0] iw, aw, ia, x1, x2, x3);
        logic [15:0] ix, b;
        case (iw[9:8])
            2'd1: ix = x1;
            2'd2: ix = x2;
            2'd3: ix = x3;
            default: ix = iw[10] ? 16'h0 : ia;
        endcase
        b = iw[10] ? ix + aw : ix + {{8{iw[7]}}, iw[7:0]};
        if (iw[10] && iw[7]) b = mem_f(b);
        return b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] iw, aw, ia, x1, x2, x3,
                       input string req, input bit poke);
        logic [15:0] ea, e_acc, e_ext;
        int cyc, lat;
        ea    = exp_ea(iw, aw, ia, x1, x2, x3);
        e_acc = mem_f(ea);
        e_ext = mem_f(ea | 16'h1);
        lat   = (iw[10] && iw[7]) ? 6 : 4;
        @(negedge clk);
        instr_word = iw; addr_word = aw; iar = ia; xr1 = x1; xr2 = x2; xr3 = x3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (poke) begin
            instr_word = 16'hC805 ^ iw; iar = ~ia; xr1 = ~x1; start = 1'b1;
        end
        while (!done && cyc < 20) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        start = 1'b0;
        check({req, " R7 latency"}, cyc, lat);
        check({req, " R6 acc"}, {16'h0, acc}, {16'h0, e_acc});
        check({req, " R6 ext"}, {16'h0, ext}, {16'h0, e_ext});
        @(negedge clk);
        check("R7 done single", {31'h0, done}, 32'h0);
        check("R7 hold acc", {16'h0, acc}, {16'h0, e_acc});
    endtask

    initial begin
        logic [15:0] iw;
        repeat (3) @(negedge clk);
        check("R1 done", {31'h0, done}, 0);
        check("R1 acc", {16'h0, acc}, 0);
        check("R1 ext", {16'h0, ext}, 0);
        check("R1 mem_re", {31'h0, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle read", {31'h0, mem_re}, 0);

        run(16'hC810, 16'h0, 16'h1000, 0, 0, 0, "R2 short fwd", 0);
        run(16'hC8F0, 16'h0, 16'h1000, 0, 0, 0, "R2 short neg", 0);
        run(16'hC880, 16'h0, 16'h0010, 0, 0, 0, "R2 wrap", 0);
        run(16'hC903, 16'h0, 16'h0, 16'h2000, 16'h3000, 16'h4000, "R3 xr1 odd", 0);
        run(16'hCAFF, 16'h0, 16'h0, 16'h2000, 16'h3000, 16'h4000, "R3 xr2 neg", 0);
        run(16'hCB80, 16'h0, 16'h0, 16'h2000, 16'h3000, 16'h4000, "R3 xr3 no ind", 0);
        run(16'hCC00, 16'hABCE, 16'h0, 0, 0, 0, "R4 long", 0);
        run(16'hCD00, 16'hFFFF, 16'h0, 16'h0004, 0, 0, "R4 long wrap", 0);
        run(16'hCC00, 16'h1235, 16'h0, 0, 0, 0, "R6 odd ea", 0);
        run(16'hCC80, 16'h0400, 16'h0, 0, 0, 0, "R5 indirect", 0);
        run(16'hCF80, 16'h0400, 16'h0, 0, 0, 16'h0022, "R5 indirect xr3", 0);
        run(16'hC820, 16'h0, 16'h5000, 16'h7000, 0, 0, "R8 busy start", 1);
        run(16'hCE80, 16'h0100, 16'h0, 0, 16'h0010, 0, "R8 busy ind", 1);

        void'($urandom(32'd2024));
        for (int i = 0; i < 150; i++) begin
            iw = {5'b11001, 11'($urandom())};
            run(iw, 16'($urandom()), 16'($urandom()), 16'($urandom()),
                16'($urandom()), 16'($urandom()), "R2 R3 R4 R5 random", (i % 7) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule